// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an eight-pin general-purpose I/O port that a processor reaches over a small synchronous register bus. Software sets, for each pin, whether it is an input or an output, the value it drives, and whether an output behaves as push-pull or as open-drain. A separate port-read register returns the stored output value for output pins and the live, synchronized pin level for input pins.

The pad side of the block produces a drive value, an output enable and a pull-up enable for every pin, and takes back the level seen on each pad. An input pin receives its pull-up only when the external pull-up request for that bit is set. An open-drain output pin never drives high. It pulls low for a data value of 0 and releases the line for a data value of 1. Bit i of every register belongs to pin i.

Top module: `gpio_port_ctrl`

## Requirements
- R1: On the clock edge where active-low `rst_n` is sampled low, the direction, data and open-drain registers clear to 0. After reset every `pad_oe` bit is 0, and reads at offsets 1 and 3 return 0.
- R2: Offset 0 holds the direction register. A bit value of 1 makes that pin an output and 0 makes it an input. The register is write-only, and a read at offset 0 always returns 0.
- R3: Offset 1 holds the data register. A write is visible on `bus_rdata` from the cycle after the write edge, and the register reads back exactly as written.
- R4: A read at offset 2 returns, for each bit, the data register bit when that pin is an output, and the synchronized pad level when it is an input. A pad change made just before clock edge k shows up on the read from edge k+1 onward, after two flops.
- R5: A write to offset 2 changes no register. The data register reads back unchanged at offset 1 afterwards.
- R6: Offset 3 holds the open-drain control register, which reads back as written.
- R7: An output pin whose open-drain bit is 0 is push-pull: `pad_oe` is 1 and `pad_out` equals the data bit.
- R8: An output pin whose open-drain bit is 1 never drives high. For a data bit of 0 it sets `pad_oe`=1 with `pad_out`=0. For a data bit of 1 it sets `pad_oe`=0, which releases the line.
- R9: An input pin always has `pad_oe`=0.
- R10: `pad_pu` is 1 for a bit exactly when that pin is an input and its `pu_req` bit is 1. Output pins, including open-drain ones, never get a pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset (0 direction, 1 data, 2 port read, 3 open-drain) |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` (combinational) |
| pad_in | input | 8 | Level seen on each pad, asynchronous |
| pu_req | input | 8 | External per-bit pull-up request |
| pad_out | output | 8 | Value driven onto each pad when enabled |
| pad_oe | output | 8 | Per-bit output enable |
| pad_pu | output | 8 | Per-bit pull-up enable |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before any check matters. They also assume that `bus_addr`, `bus_we` and `bus_wdata` are steady around each rising edge. The bench changes every bus input and pad input only on falling edges, so each value has half a period to settle. The bench models each pad as a resolved wired line: an enabled driver wins, then an external source, then the pull-up, then a board resistor. As a result, `pad_in` is always a defined level derived from the block's own outputs, and it never contains X or a drive conflict.

// File: rtl/gpio_port_pkg.sv
// Package: shared offsets and bus width of the GPIO port controller.
// Assumes a four-entry register space decoded by a two-bit offset.
package gpio_port_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DIR  = 2'd0,
        OFS_DATA = 2'd1,
        OFS_PORT = 2'd2,
        OFS_ODC  = 2'd3
    } gpio_ofs_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for the pad input levels.
// Assumes pad_in is asynchronous to clk; output lags by STAGES edges.
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // First stage samples the asynchronous pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];

    // R4: the first stage reflects the pad level sampled one edge earlier.
    p_first_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[0] == $past(async_in));
endmodule

// File: rtl/gpio_regs.sv
// Module: direction, data and open-drain registers with the read mux.
// Assumes single-cycle writes; reads are combinational from bus_addr.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  odc_q
);
    logic [WIDTH-1:0] port_view;

    // Direction register: write-only, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= '0;
        else if (bus_we && bus_addr == OFS_DIR) dir_q <= bus_wdata;
    end

    // Data register: holds the value output pins drive.
    always_ff @(posedge clk) begin
        if (!rst_n)                           data_q <= '0;
        else if (bus_we && bus_addr == OFS_DATA) data_q <= bus_wdata;
    end

    // Open-drain control register: selects output type per pin.
    always_ff @(posedge clk) begin
        if (!rst_n)                          odc_q <= '0;
        else if (bus_we && bus_addr == OFS_ODC) odc_q <= bus_wdata;
    end

    // Port view picks the latch for outputs and the pin for inputs.
    always_comb begin
        port_view = (data_q & dir_q) | (pin_sync & ~dir_q);
    end

    // Read mux; the direction offset returns zero.
    always_comb begin
        unique case (bus_addr)
            OFS_DIR:  bus_rdata = '0;
            OFS_DATA: bus_rdata = data_q;
            OFS_PORT: bus_rdata = port_view;
            OFS_ODC:  bus_rdata = odc_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R5: a write to the port-read offset leaves the data register alone.
    p_port_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_PORT) |=> $stable(data_q));

    // R3: a write to the data offset lands on the next cycle.
    p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DATA) |=> data_q == $past(bus_wdata));

    // R6: the open-drain register changes only through its own offset.
    p_odc_only_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_ODC) |=> $stable(odc_q));
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: per-pin drive, enable and pull-up decode.
// Assumes register inputs are stable registered values.
module gpio_pad_ctrl #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] odc_q,
    input  logic [WIDTH-1:0] pu_req,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            // Decode one pin: push-pull, open-drain or input.
            always_comb begin
                if (!dir_q[i]) begin
                    pad_oe[i]  = 1'b0;
                    pad_out[i] = data_q[i];
                    pad_pu[i]  = pu_req[i];
                end else if (odc_q[i]) begin
                    pad_oe[i]  = ~data_q[i];
                    pad_out[i] = 1'b0;
                    pad_pu[i]  = 1'b0;
                end else begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = data_q[i];
                    pad_pu[i]  = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: top of the eight-pin GPIO port controller.
// Assumes a synchronous register bus and asynchronous pad inputs.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    input  logic [WIDTH-1:0]  pu_req,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] odc_q;

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .data_q    (data_q),
        .odc_q     (odc_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
        .dir_q   (dir_q),
        .data_q  (data_q),
        .odc_q   (odc_q),
        .pu_req  (pu_req),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    // R1: the first cycle after reset leaves every pin undriven.
    p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pad_oe == '0);

    // R9: a pin configured as input is never driven.
    p_input_undriven_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);

    // R8: an open-drain output never drives a high level.
    p_od_no_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & odc_q & dir_q) == '0);

    // R10: pull-up never reaches an output pin.
    p_pu_inputs_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & dir_q) == '0);

    // R7: push-pull outputs are always enabled.
    p_pushpull_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~odc_q) & ~pad_oe) == '0);
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in;
    logic [W-1:0] pu_req = '0;
    logic [W-1:0] pad_out, pad_oe, pad_pu;

    logic [W-1:0] ext_en = '0, ext_val = '0, board = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Pad model: driver wins, then external source, pull-up, board resistor.
    always_comb begin
        for (int i = 0; i < W; i++)
            pad_in[i] = pad_oe[i] ? pad_out[i] :
                        ext_en[i] ? ext_val[i] :
                        pad_pu[i] ? 1'b1 : board[i];
    end

    gpio_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pu_req(pu_req), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // {dir, data, odc, pu_req, ext_en, ext_val, board}
    localparam logic [55:0] VEC [6] = '{
        56'hFF_A5_00_00_00_00_00,
        56'h00_FF_00_F0_0F_05_00,
        56'hFF_3C_FF_FF_00_00_FF,
        56'hF0_5A_30_0F_0C_08_01,
        56'h0F_96_0C_AA_00_00_55,
        56'h81_81_81_7E_3C_24_00
    };

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: an overlong run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] r;
        logic [W-1:0] dir, dat, odc, e_oe, e_out, e_pu, e_pin, e_port;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1;
        chk("R1", "pad_oe after reset", pad_oe, 8'h00);
        rd(2'd1, r); chk("R1", "data after reset", r, 8'h00);
        rd(2'd3, r); chk("R1", "odc after reset", r, 8'h00);

        // Vector walk covers R4, R7, R8, R9, R10 under varied patterns
        for (int v = 0; v < 6; v++) begin
            {dir, dat, odc, pu_req, ext_en, ext_val, board} = VEC[v];
            wr(2'd0, dir); wr(2'd1, dat); wr(2'd3, odc);
            repeat (3) @(negedge clk);
            for (int i = 0; i < W; i++) begin
                e_oe[i]  = dir[i] & (~odc[i] | ~dat[i]);
                e_out[i] = dir[i] & ~odc[i] & dat[i];
                e_pu[i]  = ~dir[i] & pu_req[i];
                e_pin[i] = e_oe[i] ? e_out[i] : ext_en[i] ? ext_val[i] :
                           e_pu[i] ? 1'b1 : board[i];
                e_port[i] = dir[i] ? dat[i] : e_pin[i];
            end
            #1;
            chk("R7/R8/R9", "pad_oe", pad_oe, e_oe);
            chk("R7/R8", "pad_out on enabled pins", pad_out & pad_oe, e_out);
            chk("R10", "pad_pu", pad_pu, e_pu);
            rd(2'd2, r); chk("R4", "port read", r, e_port);
            rd(2'd1, r); chk("R3", "data readback", r, dat);
            rd(2'd3, r); chk("R6", "odc readback", r, odc);
        end

        // R2 direction is write-only
        wr(2'd0, 8'h5A);
        rd(2'd0, r); chk("R2", "direction read", r, 8'h00);
        #1 chk("R2", "direction drives oe", pad_oe, 8'h5A);

        // R5 write to the port-read offset is ignored
        wr(2'd1, 8'hC3);
        wr(2'd2, 8'h3C);
        rd(2'd1, r); chk("R5", "data after port write", r, 8'hC3);
        rd(2'd3, r); chk("R5", "odc after port write", r, 8'h81);

        // R4 synchronizer latency on input pins
        wr(2'd0, 8'h00); wr(2'd3, 8'h00);
        ext_en = 8'hFF; ext_val = 8'h00;
        repeat (3) @(negedge clk);
        bus_addr = 2'd2;
        ext_val = 8'hE7;
        @(negedge clk); #1 chk("R4", "port read one edge after change", bus_rdata, 8'h00);
        @(negedge clk); #1 chk("R4", "port read two edges after change", bus_rdata, 8'hE7);

        // R8 open-drain release lets the external source be read back
        ext_en = 8'h00; board = 8'hFF; pu_req = 8'h00;
        wr(2'd0, 8'hFF); wr(2'd3, 8'hFF); wr(2'd1, 8'hF0);
        repeat (3) @(negedge clk); #1;
        chk("R8", "open-drain oe", pad_oe, 8'h0F);
        chk("R8", "open-drain out", pad_out, 8'h00);
        wr(2'd0, 8'h0F);
        repeat (3) @(negedge clk);
        rd(2'd2, r); chk("R4", "mixed read with released pins", r, 8'hF0);

        // R1 reset mid-run clears all registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "pad_oe after second reset", pad_oe, 8'h00);
        rd(2'd1, r); chk("R1", "data after second reset", r, 8'h00);
        rd(2'd3, r); chk("R1", "odc after second reset", r, 8'h00);

        done = 1;
        finish_run();
    end
endmodule